// File: doc/BRIEF.md
# Return Instruction Sequencer

This block carries out the two return instructions of a small 8-bit microcontroller core that has a 16-bit program counter and a hardware return stack. On every instruction-cycle strobe it inspects the current 16-bit instruction word. When the word is the interrupt return, the block pops the return stack into the program counter and clears the global interrupt-disable flag in the status register. When the word is the literal return, the block pops the stack into the program counter and loads the instruction's low byte into the working register. Any other word advances the program counter by one.

Each return takes two instruction cycles. During the second cycle the block raises `busy`, so the fetch stage holds off. The instruction word presented on that strobe is thrown away as a forced no-op. The next fetch then uses the newly loaded program counter. A test push port writes entries onto the return stack, so a bench or the surrounding core can preload return addresses.

Top module: `retseq_top`

## Requirements
- R1: While `rst_n` is low, `pc_q` is 0, `wreg_q` is 0, `status_q` is 8'h10 (the interrupt-disable flag, bit 4, is set), `busy` is 0, the stack pointer is 0 and every stack entry is 0.
- R2: When `cyc_en` is high and `busy` is low, an instruction word of exactly 16'h0005 pops the stack into `pc_q` and clears `status_q[4]`. The other status bits and `wreg_q` do not change.
- R3: When `cyc_en` is high and `busy` is low, an instruction word whose upper byte is 8'hB6 pops the stack into `pc_q` and writes the word's low byte into `wreg_q`. `status_q` does not change.
- R4: After either return, `busy` is 1 until the next `cyc_en` strobe. That strobe ignores the instruction word, leaves `pc_q`, `wreg_q`, `status_q` and the stack unchanged, and clears `busy`.
- R5: When `cyc_en` is high and `busy` is low, any other instruction word sets `pc_q` to `pc_q`+1 modulo 2^16. It leaves `wreg_q`, `status_q` and the stack unchanged.
- R6: The stack is last-in first-out: a pop returns the most recent entry that has not yet been popped.
- R7: The stack holds 16 entries and its pointer wraps modulo 16 in both directions. A 17th push overwrites the oldest entry. A pop of an empty stack returns the entry at the wrapped position, which is 0 if that entry has not been written since reset.
- R8: In a clock cycle with `cyc_en` low, `pc_q`, `wreg_q`, `status_q` and `busy` keep their values, whatever the instruction word is.
- R9: `tst_push` writes `tst_data` at the stack pointer and advances the pointer. It is ignored in a clock cycle in which a return pops the stack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_en | input | 1 | Instruction-cycle strobe |
| instr | input | 16 | Current instruction word |
| tst_push | input | 1 | Test push request |
| tst_data | input | 16 | Value pushed by `tst_push` |
| pc_q | output | 16 | Program counter |
| wreg_q | output | 8 | Working register |
| status_q | output | 8 | CPU status register, bit 4 is the interrupt-disable flag |
| busy | output | 1 | Forced no-op cycle pending, fetch must hold off |

## Verification
The bench targets the forced no-op cycle by presenting a valid return word while `busy` is high. A design that executed that word would pop the stack a second time and corrupt `pc_q`. Near misses such as 16'h0006, 16'h0105 and an upper byte of 8'hB7 must only increment the counter, so a decoder that compares too few bits shows up as a stray pop or a stray write to `wreg_q`. The bench fills the stack with seventeen pushes and then makes seventeen pops. This catches a pointer that saturates or is off by one. It also drives a test push in the same clock as a return, where a design that honoured the push would later return the wrong address.

// File: rtl/retseq_pkg.sv
package retseq_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned LIT_W   = 8;
  localparam logic [INSTR_W-1:0] INTR_RET_WORD = 16'h0005;
  localparam logic [INSTR_W-LIT_W-1:0] LIT_RET_OP = 8'hB6;
  localparam int unsigned IDIS_BIT = 4;

  typedef enum logic [1:0] {RK_NONE, RK_INTR, RK_LIT} ret_kind_e;

  function automatic ret_kind_e classify(input logic [INSTR_W-1:0] w);
    if (w == INTR_RET_WORD) return RK_INTR;
    if (w[INSTR_W-1:LIT_W] == LIT_RET_OP) return RK_LIT;
    return RK_NONE;
  endfunction

  function automatic logic [LIT_W-1:0] literal_of(input logic [INSTR_W-1:0] w);
    return w[LIT_W-1:0];
  endfunction
endpackage

// File: rtl/retseq_decode.sv
module retseq_decode
  import retseq_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output ret_kind_e          kind,
  output logic [LIT_W-1:0]   lit
);
  always_comb begin
    kind = classify(instr);
    lit  = literal_of(instr);
  end
endmodule

// File: rtl/retseq_stack.sv
module retseq_stack #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 16,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic [DW-1:0] top_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr;
  logic [PW-1:0] ptr_dec;
  logic          push_ok;

  assign ptr_dec  = ptr - PW'(1);
  assign top_data = mem[ptr_dec];
  assign push_ok  = push && !pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (pop) begin
      ptr <= ptr_dec;
    end else if (push_ok) begin
      ptr <= ptr + PW'(1);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[i] <= '0;
      else if (push_ok && ptr == PW'(i)) mem[i] <= push_data;
    end
  end

  // R9
  push_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && push) |=> (ptr == $past(ptr_dec)));
endmodule

// File: rtl/retseq_top.sv
module retseq_top
  import retseq_pkg::*;
#(
  parameter int unsigned PC_W      = 16,
  parameter int unsigned STK_DEPTH = 16,
  parameter int unsigned ST_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cyc_en,
  input  logic [INSTR_W-1:0]   instr,
  input  logic                 tst_push,
  input  logic [PC_W-1:0]      tst_data,
  output logic [PC_W-1:0]      pc_q,
  output logic [LIT_W-1:0]     wreg_q,
  output logic [ST_W-1:0]      status_q,
  output logic                 busy
);
  localparam logic [ST_W-1:0] ST_RESET = ST_W'(1) << IDIS_BIT;

  ret_kind_e        kind;
  logic [LIT_W-1:0] lit;
  logic [PC_W-1:0]  stk_top;
  logic             exec_slot;
  logic             fire_intr;
  logic             fire_lit;
  logic             fire_pop;
  logic             flush_slot;

  retseq_decode u_dec (.instr(instr), .kind(kind), .lit(lit));

  assign exec_slot  = cyc_en && !busy;
  assign flush_slot = cyc_en && busy;
  assign fire_intr  = exec_slot && (kind == RK_INTR);
  assign fire_lit   = exec_slot && (kind == RK_LIT);
  assign fire_pop   = fire_intr || fire_lit;

  retseq_stack #(.DEPTH(STK_DEPTH), .DW(PC_W)) u_stk (
    .clk(clk), .rst_n(rst_n), .pop(fire_pop), .push(tst_push),
    .push_data(tst_data), .top_data(stk_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      wreg_q   <= '0;
      status_q <= ST_RESET;
      busy     <= 1'b0;
    end else begin
      if (flush_slot) busy <= 1'b0;
      else if (fire_pop) begin
        busy <= 1'b1;
        pc_q <= stk_top;
      end else if (exec_slot) pc_q <= pc_q + PC_W'(1);
      if (fire_lit)  wreg_q <= lit;
      if (fire_intr) status_q[IDIS_BIT] <= 1'b0;
    end
  end

  // R2
  idis_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_intr |=> !status_q[IDIS_BIT]);
  // R2
  status_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q | ST_RESET) == ($past(status_q) | ST_RESET)));
  // R3
  wreg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_lit |=> $stable(wreg_q));
  // R4
  flush_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_slot |=> (!busy && $stable(pc_q)));
  // R5
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_slot && kind == RK_NONE) |=> (pc_q == $past(pc_q) + PC_W'(1)));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> ($stable(pc_q) && $stable(busy) && $stable(status_q)));
endmodule

// File: tb/retseq_top_test.sv
module retseq_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_en = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic        tst_push = 1'b0;
  logic [15:0] tst_data = 16'h0000;
  logic [15:0] pc_q;
  logic [7:0]  wreg_q;
  logic [7:0]  status_q;
  logic        busy;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  int m_pc, m_w, m_st, m_busy, m_ptr;
  int m_stk [16];

  always #10 clk = ~clk;

  retseq_top uut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .instr(instr),
    .tst_push(tst_push), .tst_data(tst_data), .pc_q(pc_q),
    .wreg_q(wreg_q), .status_q(status_q), .busy(busy)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic model_reset();
    m_pc = 0; m_w = 0; m_st = 'h10; m_busy = 0; m_ptr = 0;
    for (int i = 0; i < 16; i++) m_stk[i] = 0;
  endtask

  task automatic model_clock();
    bit popped = 0;
    if (cyc_en) begin
      if (m_busy != 0) m_busy = 0;
      else if (instr == 16'h0005 || instr[15:8] == 8'hB6) begin
        popped = 1;
        m_ptr = (m_ptr + 15) % 16;
        m_pc = m_stk[m_ptr];
        m_busy = 1;
        if (instr == 16'h0005) m_st = m_st & ~'h10;
        else m_w = int'(instr[7:0]);
      end else m_pc = (m_pc + 1) % 65536;
    end
    if (tst_push && !popped) begin
      m_stk[m_ptr] = int'(tst_data);
      m_ptr = (m_ptr + 1) % 16;
    end
  endtask

  task automatic compare(input string req);
    total++;
    if (int'(pc_q) != m_pc || int'(wreg_q) != m_w || int'(status_q) != m_st ||
        int'(busy) != m_busy) begin
      bad++;
      $display("FAIL %s: pc=%h w=%h st=%h busy=%0d expected pc=%h w=%h st=%h busy=%0d",
               req, pc_q, wreg_q, status_q, busy, m_pc[15:0], m_w[7:0], m_st[7:0],
               m_busy[0]);
    end
  endtask

  task automatic step(input logic c, input logic [15:0] w, input logic p,
                      input logic [15:0] d, input string req);
    cyc_en = c; instr = w; tst_push = p; tst_data = d;
    @(posedge clk);
    model_clock();
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    compare("R1 reset state");
    rst_n = 1'b1;

    // R9: preload three return addresses
    step(0, 16'h0000, 1, 16'h1234, "R9 push");
    step(0, 16'h0000, 1, 16'hABCD, "R9 push");
    step(0, 16'h0000, 1, 16'h0042, "R9 push");
    // R5: ordinary words advance the counter
    for (int i = 0; i < 3; i++) step(1, 16'h1111, 0, 16'h0, "R5 increment");
    // R8: no strobe, return word present
    step(0, 16'hB699, 0, 16'h0, "R8 idle");
    step(0, 16'h0005, 0, 16'h0, "R8 idle");
    // R3 literal return, then R4 flush ignoring a valid return word
    step(1, 16'hB65A, 0, 16'h0, "R3 literal return");
    step(0, 16'h0005, 0, 16'h0, "R8 idle while busy");
    step(1, 16'h0005, 0, 16'h0, "R4 forced no-op");
    // R2 interrupt return, R6 order
    step(1, 16'h0005, 0, 16'h0, "R2 R6 interrupt return");
    step(1, 16'hB611, 0, 16'h0, "R4 forced no-op");
    // R5 near misses
    step(1, 16'h0006, 0, 16'h0, "R5 near miss");
    step(1, 16'h0105, 0, 16'h0, "R5 near miss");
    step(1, 16'hB700, 0, 16'h0, "R5 near miss");
    step(1, 16'hFFFF, 0, 16'h0, "R5 near miss");
    // R9 push ignored when a return pops in the same clock
    step(1, 16'hB6C3, 1, 16'hDEAD, "R9 push blocked");
    step(1, 16'h2222, 0, 16'h0, "R4 forced no-op");
    // R7 empty pop wraps to a never-written entry
    step(1, 16'hB601, 0, 16'h0, "R7 empty pop");
    step(1, 16'h0000, 0, 16'h0, "R4 forced no-op");
    // R7 R6: seventeen pushes, seventeen pops
    for (int i = 0; i < 17; i++)
      step(0, 16'h0000, 1, 16'h4000 + 16'(i * 3), "R7 fill");
    for (int i = 0; i < 17; i++) begin
      step(1, 16'hB600 + 16'(i), 0, 16'h0, "R6 R7 drain");
      step(1, 16'h0005, 0, 16'h0, "R4 forced no-op");
    end
    step(1, 16'h0005, 0, 16'h0, "R2 after drain");
    step(1, 16'h0000, 0, 16'h0, "R4 forced no-op");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule